// File: doc/BRIEF.md
# Integer Execute Unit with Iterative Divider

This block is the integer execute stage of a 32-bit load/store processor core. The issue logic presents an instruction word, the two source operand values read from the register file, and a one-cycle start strobe. The unit decodes the word and works out the result: addition, subtraction, bitwise logic, low-half multiply, the four shift and rotate kinds, placing an immediate in the upper half, or a signed or unsigned quotient. It returns the result together with the destination register index and a one-cycle done strobe. The writeback stage uses these to update the register file.

Every operation except division finishes in a single cycle. Division runs through a restoring divider, one quotient bit per cycle, and the unit takes no new work until the quotient is ready. A division by zero produces no result. Instead the unit pulses an illegal-operation trap, and the exception logic outside the block acts on it. Instruction words that match no supported encoding are dropped without any response.

Top module: `exu_int`

## Requirements
- R1: A register-form word has bits 31:30 = 3 and bits 29:26 = 8. With bits 10:4 all zero, bits 3:0 choose the operation: 0 add, 2 subtract, 3 AND, 4 OR, 5 XOR, 6 multiply (low 32 bits), each on the first and second operands. When started, result_o holds the value and done_o is high for the cycle after the start edge.
- R2: An immediate-form word has bits 31:30 = 2. With bits 29:26 = 5 (add) or 7 (subtract), the 16-bit immediate in bits 15:0 is sign-extended and takes the place of the second operand.
- R3: With bits 31:30 = 2 and bits 29:26 = 8 (AND), 9 (OR), 10 (XOR) or 11 (multiply), the immediate is zero-extended.
- R4: A register-form word with bits 3:0 = 8, bits 10:8 = 0 and bit 4 = 0 shifts the first operand by the low 5 bits of the second operand. Bits 7:5 choose the kind: 0 left, 1 logical right, 2 arithmetic right, 4 rotate right.
- R5: A word with bits 31:30 = 2, bits 29:26 = 13 and bits 15:8 = 0 shifts by the amount in bits 4:0, with the same kind selector in bits 7:5.
- R6: A word with bits 31:30 = 0 and bits 29:26 = 6 returns the immediate in bits 31:16 of the result and zeros in bits 15:0.
- R7: dest_o carries bits 25:21 of the word that produced the result, and it changes together with done_o.
- R8: A register-form word with bits 3:0 = 9 (signed) or 10 (unsigned) and a nonzero second operand divides the first operand by the second. Signed quotients truncate toward zero, and the most negative value divided by -1 gives 0x80000000. done_o rises 32 cycles after the start edge.
- R9: A divide whose second operand is zero makes trap_o high for the one cycle after the start edge. done_o stays low, and result_o and dest_o keep their previous values.
- R10: While a division is in progress, including its last iteration cycle, start_i is ignored. A start in the cycle after completion is accepted.
- R11: A word that matches no encoding above, including a shift with selector 3, 5, 6 or 7, is ignored. It causes no done and no trap, and result_o and dest_o are unchanged.
- R12: While rst_n is low, done_o and trap_o are low and result_o and dest_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for the presented word |
| insn_i | input | 32 | Instruction word |
| opa_i | input | 32 | First source operand value |
| opb_i | input | 32 | Second source operand value |
| result_o | output | 32 | Result of the last completed operation |
| dest_o | output | 5 | Destination register index of that result |
| done_o | output | 1 | One-cycle strobe: result_o and dest_o are new |
| trap_o | output | 1 | One-cycle illegal-operation strobe on a zero divisor |

## Verification
A division can finish in the same cycle that a new start arrives. To provoke this, a second instruction is timed so that the edge sampling it is the divider's 32nd iteration edge, and another instruction follows it one cycle later. The bench's behavioural model treats the first of these starts as dropped. It expects only the quotient and its destination in that cycle, and then the following instruction's result one cycle later. A further check checks that a trap and a done never appear together.

// File: rtl/exu_pkg.sv
package exu_pkg;

    localparam int INSN_W = 32;
    localparam int REG_IDX_W = 5;
    localparam int IMM_W = 16;

    localparam logic [1:0] CLS_HIGH = 2'd0;
    localparam logic [1:0] CLS_IMM  = 2'd2;
    localparam logic [1:0] CLS_REG  = 2'd3;

    localparam logic [3:0] GRP_REG   = 4'd8;
    localparam logic [3:0] GRP_HIGH  = 4'd6;
    localparam logic [3:0] GRP_ISHF  = 4'd13;

    localparam logic [3:0] IGRP_ADD = 4'd5;
    localparam logic [3:0] IGRP_SUB = 4'd7;
    localparam logic [3:0] IGRP_AND = 4'd8;
    localparam logic [3:0] IGRP_OR  = 4'd9;
    localparam logic [3:0] IGRP_XOR = 4'd10;
    localparam logic [3:0] IGRP_MUL = 4'd11;

    localparam logic [3:0] FN_ADD   = 4'd0;
    localparam logic [3:0] FN_SUB   = 4'd2;
    localparam logic [3:0] FN_AND   = 4'd3;
    localparam logic [3:0] FN_OR    = 4'd4;
    localparam logic [3:0] FN_XOR   = 4'd5;
    localparam logic [3:0] FN_MUL   = 4'd6;
    localparam logic [3:0] FN_SHIFT = 4'd8;
    localparam logic [3:0] FN_DIVS  = 4'd9;
    localparam logic [3:0] FN_DIVU  = 4'd10;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_ADD,
        OP_SUB,
        OP_AND,
        OP_OR,
        OP_XOR,
        OP_MUL,
        OP_SHIFT,
        OP_HIGH,
        OP_DIVS,
        OP_DIVU
    } exu_op_e;

    typedef enum logic [1:0] {
        SHF_LEFT,
        SHF_RLOG,
        SHF_RARITH,
        SHF_ROTR
    } shf_kind_e;

    typedef struct packed {
        exu_op_e              op;
        shf_kind_e            shf;
        logic                 use_imm;
        logic                 imm_sext;
        logic [REG_IDX_W-1:0] rd;
        logic [IMM_W-1:0]     imm;
    } exu_dec_t;

    function automatic logic shf_sel_valid(input logic [2:0] sel);
        return (sel == 3'd0) || (sel == 3'd1) || (sel == 3'd2) || (sel == 3'd4);
    endfunction

    function automatic shf_kind_e shf_sel_kind(input logic [2:0] sel);
        shf_kind_e k;
        case (sel)
            3'd1:    k = SHF_RLOG;
            3'd2:    k = SHF_RARITH;
            3'd4:    k = SHF_ROTR;
            default: k = SHF_LEFT;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output exu_dec_t          dec_o
);

    logic [1:0] cls;
    logic [3:0] grp;
    logic [3:0] fn;
    logic [2:0] sel;
    logic       unused_src;

    assign cls = insn_i[31:30];
    assign grp = insn_i[29:26];
    assign fn  = insn_i[3:0];
    assign sel = insn_i[7:5];
    assign unused_src = ^insn_i[20:16];

    always_comb begin
        dec_o          = '0;
        dec_o.op       = OP_NONE;
        dec_o.shf      = shf_sel_kind(sel);
        dec_o.rd       = insn_i[25:21];
        dec_o.imm      = insn_i[15:0];
        dec_o.use_imm  = 1'b0;
        dec_o.imm_sext = 1'b0;

        if (cls == CLS_REG && grp == GRP_REG) begin
            if (fn == FN_SHIFT) begin
                if (insn_i[10:8] == 3'd0 && !insn_i[4] && shf_sel_valid(sel)) begin
                    dec_o.op = OP_SHIFT;
                end
            end else if (insn_i[10:4] == 7'd0) begin
                case (fn)
                    FN_ADD:  dec_o.op = OP_ADD;
                    FN_SUB:  dec_o.op = OP_SUB;
                    FN_AND:  dec_o.op = OP_AND;
                    FN_OR:   dec_o.op = OP_OR;
                    FN_XOR:  dec_o.op = OP_XOR;
                    FN_MUL:  dec_o.op = OP_MUL;
                    FN_DIVS: dec_o.op = OP_DIVS;
                    FN_DIVU: dec_o.op = OP_DIVU;
                    default: dec_o.op = OP_NONE;
                endcase
            end
        end else if (cls == CLS_IMM) begin
            dec_o.use_imm = 1'b1;
            case (grp)
                IGRP_ADD: begin dec_o.op = OP_ADD; dec_o.imm_sext = 1'b1; end
                IGRP_SUB: begin dec_o.op = OP_SUB; dec_o.imm_sext = 1'b1; end
                IGRP_AND: dec_o.op = OP_AND;
                IGRP_OR:  dec_o.op = OP_OR;
                IGRP_XOR: dec_o.op = OP_XOR;
                IGRP_MUL: dec_o.op = OP_MUL;
                GRP_ISHF: begin
                    if (insn_i[15:8] == 8'd0 && shf_sel_valid(sel)) begin
                        dec_o.op = OP_SHIFT;
                    end
                end
                default:  dec_o.op = OP_NONE;
            endcase
        end else if (cls == CLS_HIGH && grp == GRP_HIGH) begin
            dec_o.op = OP_HIGH;
        end
    end

endmodule

// File: rtl/exu_shifter.sv
module exu_shifter
    import exu_pkg::*;
#(
    parameter int DW = 32,
    localparam int SHW = $clog2(DW)
) (
    input  logic [DW-1:0]  val_i,
    input  logic [SHW-1:0] amt_i,
    input  shf_kind_e      kind_i,
    output logic [DW-1:0]  val_o
);

    logic [2*DW-1:0] doubled;

    assign doubled = {val_i, val_i} >> amt_i;

    always_comb begin
        case (kind_i)
            SHF_LEFT:   val_o = val_i << amt_i;
            SHF_RLOG:   val_o = val_i >> amt_i;
            SHF_RARITH: val_o = DW'($signed(val_i) >>> amt_i);
            default:    val_o = doubled[DW-1:0];
        endcase
    end

endmodule

// File: rtl/exu_divider.sv
module exu_divider
    import exu_pkg::*;
#(
    parameter int DW = 32,
    localparam int CW = $clog2(DW)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic                 signed_i,
    input  logic [DW-1:0]        dividend_i,
    input  logic [DW-1:0]        divisor_i,
    input  logic [REG_IDX_W-1:0] rd_i,
    output logic                 busy_o,
    output logic                 fin_o,
    output logic [DW-1:0]        quo_o,
    output logic [REG_IDX_W-1:0] rd_o
);

    typedef struct packed {
        logic                 busy;
        logic [CW-1:0]        cnt;
        logic [DW-1:0]        rem;
        logic [DW-1:0]        quo;
        logic [DW-1:0]        dvs;
        logic                 neg;
        logic [REG_IDX_W-1:0] rd;
    } div_st_t;

    div_st_t st_d, st_q;

    logic [DW:0]   shifted;
    logic [DW:0]   trial;
    logic          fits;
    logic [DW-1:0] rem_nx;
    logic [DW-1:0] quo_nx;

    function automatic logic [DW-1:0] magnitude(input logic [DW-1:0] v, input logic sgn);
        return (sgn && v[DW-1]) ? (~v + 1'b1) : v;
    endfunction

    assign shifted = {st_q.rem, st_q.quo[DW-1]};
    assign trial   = shifted - {1'b0, st_q.dvs};
    assign fits    = !trial[DW];
    assign rem_nx  = fits ? trial[DW-1:0] : shifted[DW-1:0];
    assign quo_nx  = {st_q.quo[DW-2:0], fits};

    assign busy_o = st_q.busy;
    assign fin_o  = st_q.busy && (st_q.cnt == CW'(DW - 1));
    assign quo_o  = st_q.neg ? (~quo_nx + 1'b1) : quo_nx;
    assign rd_o   = st_q.rd;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.rem  = '0;
            st_d.quo  = magnitude(dividend_i, signed_i);
            st_d.dvs  = magnitude(divisor_i, signed_i);
            st_d.neg  = signed_i && (dividend_i[DW-1] ^ divisor_i[DW-1]);
            st_d.rd   = rd_i;
        end else if (st_q.busy) begin
            st_d.rem = rem_nx;
            st_d.quo = quo_nx;
            st_d.cnt = st_q.cnt + 1'b1;
            if (fin_o) begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/exu_int.sv
module exu_int
    import exu_pkg::*;
#(
    parameter int DW = 32,
    localparam int SHW = $clog2(DW)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [INSN_W-1:0]    insn_i,
    input  logic [DW-1:0]        opa_i,
    input  logic [DW-1:0]        opb_i,
    output logic [DW-1:0]        result_o,
    output logic [REG_IDX_W-1:0] dest_o,
    output logic                 done_o,
    output logic                 trap_o
);

    typedef struct packed {
        logic [DW-1:0]        res;
        logic [REG_IDX_W-1:0] rd;
        logic                 done;
        logic                 trap;
    } out_st_t;

    out_st_t st_d, st_q;

    exu_dec_t             dec;
    logic [DW-1:0]        opnd_b;
    logic [DW-1:0]        shf_y;
    logic [DW-1:0]        alu_y;
    logic                 div_busy;
    logic                 div_fin;
    logic [DW-1:0]        div_quo;
    logic [REG_IDX_W-1:0] div_rd;
    logic                 accept;
    logic                 is_div;
    logic                 zero_div;
    logic                 div_load;

    exu_decode u_dec (
        .insn_i (insn_i),
        .dec_o  (dec)
    );

    always_comb begin
        if (!dec.use_imm) begin
            opnd_b = opb_i;
        end else if (dec.imm_sext) begin
            opnd_b = {{(DW-IMM_W){dec.imm[IMM_W-1]}}, dec.imm};
        end else begin
            opnd_b = {{(DW-IMM_W){1'b0}}, dec.imm};
        end
    end

    exu_shifter #(.DW(DW)) u_shf (
        .val_i  (opa_i),
        .amt_i  (opnd_b[SHW-1:0]),
        .kind_i (dec.shf),
        .val_o  (shf_y)
    );

    always_comb begin
        case (dec.op)
            OP_ADD:   alu_y = opa_i + opnd_b;
            OP_SUB:   alu_y = opa_i - opnd_b;
            OP_AND:   alu_y = opa_i & opnd_b;
            OP_OR:    alu_y = opa_i | opnd_b;
            OP_XOR:   alu_y = opa_i ^ opnd_b;
            OP_MUL:   alu_y = opa_i * opnd_b;
            OP_SHIFT: alu_y = shf_y;
            OP_HIGH:  alu_y = {dec.imm, {(DW-IMM_W){1'b0}}};
            default:  alu_y = '0;
        endcase
    end

    assign accept   = start_i && !div_busy;
    assign is_div   = (dec.op == OP_DIVS) || (dec.op == OP_DIVU);
    assign zero_div = (opb_i == '0);
    assign div_load = accept && is_div && !zero_div;

    exu_divider #(.DW(DW)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (div_load),
        .signed_i   (dec.op == OP_DIVS),
        .dividend_i (opa_i),
        .divisor_i  (opb_i),
        .rd_i       (dec.rd),
        .busy_o     (div_busy),
        .fin_o      (div_fin),
        .quo_o      (div_quo),
        .rd_o       (div_rd)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.trap = 1'b0;
        if (div_fin) begin
            st_d.res  = div_quo;
            st_d.rd   = div_rd;
            st_d.done = 1'b1;
        end else if (accept && dec.op != OP_NONE) begin
            if (is_div) begin
                st_d.trap = zero_div;
            end else begin
                st_d.res  = alu_y;
                st_d.rd   = dec.rd;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.res;
    assign dest_o   = st_q.rd;
    assign done_o   = st_q.done;
    assign trap_o   = st_q.trap;

endmodule

// File: rtl/exu_int_chk.sv
module exu_int_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done_o,
    input logic          trap_o,
    input logic [DW-1:0] result_o,
    input logic [4:0]    dest_o,
    input logic          div_busy
);

    assert_no_done_with_trap_R9: assert property (
        @(posedge clk) disable iff (!rst_n) !(done_o && trap_o));

    assert_trap_keeps_result_R9: assert property (
        @(posedge clk) disable iff (!rst_n) trap_o |-> ($stable(result_o) && $stable(dest_o)));

    assert_busy_blocks_output_R10: assert property (
        @(posedge clk) disable iff (!rst_n) div_busy |-> (!done_o && !trap_o));

    assert_div_finish_done_R8: assert property (
        @(posedge clk) disable iff (!rst_n) $fell(div_busy) |-> done_o);

    assert_reset_quiet_R12: assert property (
        @(posedge clk) !rst_n |=> (!done_o && !trap_o));

endmodule

bind exu_int exu_int_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done_o   (done_o),
    .trap_o   (trap_o),
    .result_o (result_o),
    .dest_o   (dest_o),
    .div_busy (div_busy)
);

// File: tb/sim_exu_int.sv
`timescale 1ns/1ps
module sim_exu_int;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [31:0] result_o;
    logic [4:0]  dest_o;
    logic        done_o;
    logic        trap_o;

    int n_tests = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    exu_int u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .insn_i   (insn),
        .opa_i    (opa),
        .opb_i    (opb),
        .result_o (result_o),
        .dest_o   (dest_o),
        .done_o   (done_o),
        .trap_o   (trap_o)
    );

    // word builders
    function automatic logic [31:0] w_rr(input logic [3:0] fn, input logic [4:0] rd);
        return {2'd3, 4'd8, rd, 5'd1, 5'd2, 7'd0, fn};
    endfunction
    function automatic logic [31:0] w_ri(input logic [3:0] grp, input logic [4:0] rd, input logic [15:0] imm);
        return {2'd2, grp, rd, 5'd3, imm};
    endfunction
    function automatic logic [31:0] w_sr(input logic [2:0] sel, input logic [4:0] rd);
        return {2'd3, 4'd8, rd, 5'd1, 5'd2, 3'd0, sel, 1'b0, 4'd8};
    endfunction
    function automatic logic [31:0] w_si(input logic [2:0] sel, input logic [4:0] rd, input logic [4:0] amt);
        return {2'd2, 4'd13, rd, 5'd1, 8'd0, sel, amt};
    endfunction
    function automatic logic [31:0] w_hi(input logic [4:0] rd, input logic [15:0] imm);
        return {2'd0, 4'd6, rd, 5'd0, imm};
    endfunction

    function automatic logic [31:0] ref_shift(input logic [31:0] a, input logic [2:0] sel, input int amt);
        logic [63:0] d;
        d = {a, a} >> amt;
        case (sel)
            3'd0: return a << amt;
            3'd1: return a >> amt;
            3'd2: return $signed(a) >>> amt;
            default: return d[31:0];
        endcase
    endfunction

    // kind: 0 ignored, 1 single cycle, 2 divide, 3 trap
    task automatic ref_eval(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                            output int kind, output logic [31:0] r, output string tag);
        logic [31:0] se, ze;
        longint sa, sb, q;
        se = {{16{w[15]}}, w[15:0]};
        ze = {16'd0, w[15:0]};
        kind = 0; r = '0; tag = "R11";
        if (w[31:30] == 2'd3 && w[29:26] == 4'd8) begin
            if (w[3:0] == 4'd8) begin
                if (w[10:8] == 0 && !w[4] && w[7:5] inside {3'd0, 3'd1, 3'd2, 3'd4}) begin
                    kind = 1; r = ref_shift(a, w[7:5], int'(b[4:0])); tag = "R4";
                end
            end else if (w[10:4] == 0) begin
                tag = "R1"; kind = 1;
                case (w[3:0])
                    4'd0: r = a + b;
                    4'd2: r = a - b;
                    4'd3: r = a & b;
                    4'd4: r = a | b;
                    4'd5: r = a ^ b;
                    4'd6: r = a * b;
                    4'd9, 4'd10: begin
                        if (b == 0) begin kind = 3; tag = "R9"; end
                        else begin
                            kind = 2; tag = "R8";
                            if (w[3:0] == 4'd9) begin
                                sa = longint'($signed(a)); sb = longint'($signed(b));
                                q = sa / sb; r = q[31:0];
                            end else begin
                                r = a / b;
                            end
                        end
                    end
                    default: begin kind = 0; tag = "R11"; end
                endcase
            end
        end else if (w[31:30] == 2'd2) begin
            kind = 1;
            case (w[29:26])
                4'd5:  begin r = a + se; tag = "R2"; end
                4'd7:  begin r = a - se; tag = "R2"; end
                4'd8:  begin r = a & ze; tag = "R3"; end
                4'd9:  begin r = a | ze; tag = "R3"; end
                4'd10: begin r = a ^ ze; tag = "R3"; end
                4'd11: begin r = a * ze; tag = "R3"; end
                4'd13: begin
                    if (w[15:8] == 0 && w[7:5] inside {3'd0, 3'd1, 3'd2, 3'd4}) begin
                        r = ref_shift(a, w[7:5], int'(w[4:0])); tag = "R5";
                    end else kind = 0;
                end
                default: kind = 0;
            endcase
        end else if (w[31:30] == 2'd0 && w[29:26] == 4'd6) begin
            kind = 1; r = {w[15:0], 16'd0}; tag = "R6";
        end
    endtask

    // behavioural reference model
    logic [31:0] e_res = '0;
    logic [4:0]  e_dest = '0;
    logic        e_done = 1'b0;
    logic        e_trap = 1'b0;
    string       e_tag = "R12";
    int          m_cnt = 0;
    logic [31:0] m_q = '0;
    logic [4:0]  m_d = '0;

    always @(posedge clk) begin
        int k;
        logic [31:0] r;
        string tg;
        logic was_busy;
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; e_done = 0; e_trap = 0; e_res = '0; e_dest = '0;
        end else begin
            was_busy = (m_cnt != 0);
            e_done = 0; e_trap = 0;
            if (m_cnt != 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    e_done = 1; e_res = m_q; e_dest = m_d; e_tag = "R8";
                end
            end
            if (start) begin
                if (was_busy) begin
                    e_tag = "R10";
                end else begin
                    ref_eval(insn, opa, opb, k, r, tg);
                    e_tag = tg;
                    case (k)
                        1: begin e_done = 1; e_res = r; e_dest = insn[25:21]; end
                        2: begin m_cnt = 32; m_q = r; m_d = insn[25:21]; end
                        3: e_trap = 1;
                        default: ;
                    endcase
                end
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_tests += 4;
            if (done_o !== e_done) begin
                n_fail++; $display("FAIL %s done actual=%0b expected=%0b", e_tag, done_o, e_done);
            end
            if (trap_o !== e_trap) begin
                n_fail++; $display("FAIL %s trap actual=%0b expected=%0b", e_tag, trap_o, e_trap);
            end
            if (result_o !== e_res) begin
                n_fail++; $display("FAIL %s result actual=%h expected=%h", e_tag, result_o, e_res);
            end
            if (dest_o !== e_dest) begin
                n_fail++; $display("FAIL R7 (%s) dest actual=%0d expected=%0d", e_tag, dest_o, e_dest);
            end
        end
    end

    task automatic drive(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        start = 1'b1; insn = w; opa = a; opb = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        wait (cyc == 150000);
        n_tests++; n_fail++;
        $display("FAIL R8 watchdog actual=%0d cycles expected=end of run", cyc);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        n_tests++;
        if (done_o !== 0 || trap_o !== 0 || result_o !== 0 || dest_o !== 0) begin
            n_fail++;
            $display("FAIL R12 reset actual=%0b%0b %h %0d expected=00 0 0", done_o, trap_o, result_o, dest_o);
        end
        rst_n = 1'b1;
        idle(2);

        // R1 register arithmetic, back to back
        drive(w_rr(4'd0, 5'd4), 32'h7fff_ffff, 32'd1);
        drive(w_rr(4'd2, 5'd5), 32'd3, 32'd10);
        drive(w_rr(4'd3, 5'd6), 32'hf0f0_1234, 32'h0ff0_ff00);
        drive(w_rr(4'd4, 5'd7), 32'h1200_0000, 32'h0000_0034);
        drive(w_rr(4'd5, 5'd8), 32'hdead_beef, 32'hffff_ffff);
        drive(w_rr(4'd6, 5'd9), 32'h1234_5678, 32'h9abc_def0);
        // R2 sign-extended immediates, R3 zero-extended
        drive(w_ri(4'd5, 5'd10, 16'hfffe), 32'd5, 32'hx);
        drive(w_ri(4'd7, 5'd11, 16'h8000), 32'd0, 32'd0);
        drive(w_ri(4'd8, 5'd12, 16'hff0f), 32'hffff_ffff, 32'd0);
        drive(w_ri(4'd9, 5'd13, 16'h8001), 32'h0, 32'd0);
        drive(w_ri(4'd10, 5'd14, 16'hffff), 32'h8000_0000, 32'd0);
        drive(w_ri(4'd11, 5'd15, 16'hffff), 32'd3, 32'd0);
        // R4 / R5 shifts
        drive(w_sr(3'd0, 5'd16), 32'h8000_0001, 32'hffff_ffe4);
        drive(w_sr(3'd1, 5'd17), 32'h8000_0000, 32'd31);
        drive(w_sr(3'd2, 5'd18), 32'h8000_0000, 32'd31);
        drive(w_sr(3'd4, 5'd19), 32'h1234_5678, 32'd8);
        drive(w_si(3'd4, 5'd20, 5'd0), 32'hcafe_f00d, 32'd0);
        drive(w_si(3'd2, 5'd21, 5'd4), 32'hf000_0000, 32'd0);
        drive(w_si(3'd0, 5'd22, 5'd31), 32'h3, 32'd0);
        // R6 load high
        drive(w_hi(5'd23, 16'habcd), 32'hffff_ffff, 32'hffff_ffff);
        // R11 ignored encodings
        drive(32'h4000_0000, 32'd1, 32'd1);
        drive(w_rr(4'd0, 5'd1) | 32'h10, 32'd1, 32'd1);
        drive(w_sr(3'd3, 5'd2), 32'd1, 32'd1);
        drive(w_rr(4'd7, 5'd3), 32'd1, 32'd1);
        drive(w_si(3'd6, 5'd3, 5'd1), 32'd1, 32'd1);
        idle(2);

        // R8 divides
        drive(w_rr(4'd9, 5'd24), 32'hffff_fff9, 32'd2);
        idle(33);
        drive(w_rr(4'd9, 5'd25), 32'd7, 32'hffff_fffe);
        idle(33);
        drive(w_rr(4'd9, 5'd26), 32'h8000_0000, 32'hffff_ffff);
        idle(33);
        drive(w_rr(4'd10, 5'd27), 32'hffff_ffff, 32'd3);
        idle(33);
        drive(w_rr(4'd10, 5'd28), 32'd5, 32'd9);
        idle(33);
        // R9 zero divisor, around other results
        drive(w_rr(4'd0, 5'd29), 32'd1, 32'd2);
        drive(w_rr(4'd9, 5'd30), 32'd100, 32'd0);
        drive(w_rr(4'd10, 5'd31), 32'd100, 32'd0);
        idle(3);

        // R10 starts while busy, one on the final iteration cycle
        drive(w_rr(4'd10, 5'd1), 32'd1000, 32'd7);
        drive(w_rr(4'd0, 5'd2), 32'd1, 32'd1);
        idle(30);
        drive(w_rr(4'd4, 5'd3), 32'h55, 32'haa);
        drive(w_rr(4'd5, 5'd4), 32'h0f, 32'hff);
        idle(3);

        // mixed stream
        for (int i = 0; i < 400; i++) begin
            logic [31:0] w, a, b;
            int p;
            p = int'($urandom % 10);
            a = $urandom;
            b = $urandom >> ($urandom % 32);
            case (p)
                0: w = w_rr(4'($urandom % 7), 5'($urandom));
                1: w = w_ri(4'(5 + $urandom % 7), 5'($urandom), 16'($urandom));
                2: w = w_sr(3'($urandom % 8), 5'($urandom));
                3: w = w_si(3'($urandom % 8), 5'($urandom), 5'($urandom));
                4: w = w_hi(5'($urandom), 16'($urandom));
                5, 6: begin
                    w = w_rr(($urandom % 2) ? 4'd9 : 4'd10, 5'($urandom));
                    if ($urandom % 4 == 0) b = 32'd0;
                end
                default: w = $urandom;
            endcase
            drive(w, a, b);
            if ($urandom % 3 == 0) idle(int'($urandom % 40));
        end
        idle(40);
        finish_run();
    end

endmodule